// File: doc/BRIEF.md
# Audio FSK Tone Demodulator with Bit Clock Recovery

This block turns a stream of audio samples, arriving at eight samples per bit, into a stream of decoded data bits. Each sample is multiplied by the sample taken half a bit earlier. The mark and space tones then give products of opposite average sign. A first-order recursive low-pass filter smooths the product, and it uses only shifts and adds. The sign of the filtered value is kept in a short history of sliced bits.

A phase accumulator recovers the bit timing. It moves a small step toward every transition it sees in the sliced history. When it wraps, the block takes a 3-of-5 majority vote over the newest sliced bits. It then emits the NRZI-decoded result: a 1 when the voted bit equals the previous voted bit, and a 0 when it differs.

An optional front end accepts raw unsigned 12-bit converter codes and tracks their DC level. It removes that level and scales the result to a signed 8-bit sample. Samples enter and bits leave through valid/ready streams. A sample is taken when `in_valid` and `in_ready` are both high. A produced bit stays on `out_bit`, with `out_valid` high, until a cycle with `out_ready` high. While that bit waits, `in_ready` is low, so no input sample is lost and no bit is dropped.

Top module: `afsk_demod`

## Requirements
- R1: The half-bit delay line holds 4 samples and starts from zeros. For the first 4 accepted samples, the delayed operand is 0.
- R2: For each accepted sample s, with delayed sample d, the 16-bit product is p = d*s and the filter term is x = (p>>>2)+(p>>>5). The filter output is y = x_prev + x + (y_prev>>>2) + (y_prev>>>3) + (y_prev>>>4), computed with arithmetic shifts and wrapped to 16-bit two's complement.
- R3: After each accepted sample, a sliced bit enters the history. The bit is 1 when the new y is strictly greater than zero, and 0 otherwise.
- R4: When the two newest sliced bits differ, the phase counter changes before the step is added. It rises by 4 when it is below 128 and falls by 4 otherwise. In every accepted sample it then advances by 32.
- R5: When the phase counter reaches 256 or more, it wraps modulo 256 and a bit is produced. The voted bit is 1 when at least 3 of the 5 newest sliced bits are 1.
- R6: The output bit is 1 when the voted bit equals the previous voted bit, and 0 otherwise. The previous voted bit is 0 after reset.
- R7: With the front end enabled, every accepted 12-bit code is summed. On the 192nd code, the offset becomes the sum divided by 192, truncated, and that new offset already applies to that code. An average above 3300 or below 1300 sets the offset to 2303. The sample is (code − offset) >>> 4, keeping the low 8 bits as a signed value.
- R8: `out_valid` and `out_bit` stay unchanged while `out_valid` is high and `out_ready` is low. During such cycles `in_ready` is low. Otherwise `in_ready` is high.
- R9: After reset, `out_valid` is 0, `in_ready` is 1, the offset is 2303, and the phase counter, the sliced history and the filter state are 0.
- R10: With the front end disabled, the sample is bits 7:0 of `in_data`, read as two's complement. Bits 11:8 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 12 | Raw code (front end on) or signed sample in bits 7:0 |
| out_valid | output | 1 | Decoded bit present |
| out_ready | input | 1 | Consumer takes the bit |
| out_bit | output | 1 | NRZI-decoded data bit |

## Verification
The bench builds two copies of the block. One has the DC front end enabled and is driven with ready stalls. The other has the front end disabled and its output always ready. The enabled copy is fed tone bursts whose DC level sits inside the accepted window, above it, and below it. This covers the averaging, the clamp to the default offset, and the back-pressure path. The disabled copy sees the same codes, so the upper input bits vary freely, and random noise drives many transitions and nudges of the phase counter.

// File: rtl/afsk_pkg.sv
package afsk_pkg;
  localparam int SAMPLE_W = 8;
  localparam int PROD_W   = 2 * SAMPLE_W;
  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic signed [PROD_W-1:0]   acc_t;
endpackage

// File: rtl/afsk_dc_remove.sv
module afsk_dc_remove
  import afsk_pkg::*;
#(
  parameter int RAW_W   = 12,
  parameter int AVG_LEN = 192,
  parameter int OFF_LO  = 1300,
  parameter int OFF_HI  = 3300,
  parameter int OFF_DEF = 2303
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [RAW_W-1:0] raw,
  output sample_t          sample
);
  localparam int SUM_W = $clog2(AVG_LEN * ((1 << RAW_W) - 1) + 1);
  localparam int CNT_W = $clog2(AVG_LEN + 1);
  localparam int DIF_W = RAW_W + 1;

  logic [RAW_W-1:0] offset_q, off_use, avg_clamped;
  logic [SUM_W-1:0] sum_q, sum_next, avg;
  logic [CNT_W-1:0] cnt_q;
  logic             block_end;
  logic signed [DIF_W-1:0] diff, scaled;

  always_comb begin
    sum_next  = sum_q + SUM_W'(raw);
    block_end = (cnt_q == CNT_W'(AVG_LEN - 1));
    avg       = sum_next / SUM_W'(AVG_LEN);
    if (avg > SUM_W'(OFF_HI) || avg < SUM_W'(OFF_LO)) avg_clamped = RAW_W'(OFF_DEF);
    else                                               avg_clamped = avg[RAW_W-1:0];
    off_use   = block_end ? avg_clamped : offset_q;
    diff      = $signed({1'b0, raw}) - $signed({1'b0, off_use});
    scaled    = diff >>> 4;
    sample    = scaled[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offset_q <= RAW_W'(OFF_DEF);
      sum_q    <= '0;
      cnt_q    <= '0;
    end else if (acc) begin
      if (block_end) begin
        offset_q <= avg_clamped;
        sum_q    <= '0;
        cnt_q    <= '0;
      end else begin
        sum_q <= sum_next;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_OFFSET_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (offset_q >= RAW_W'(OFF_LO)) && (offset_q <= RAW_W'(OFF_HI))) // R7
    else $error("offset left its window");
  AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(offset_q)) // R7
    else $error("offset moved without a sample");
endmodule

// File: rtl/afsk_discrim.sv
module afsk_discrim
  import afsk_pkg::*;
#(
  parameter int HALF   = 4,
  parameter int HIST_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  sample_t           sample,
  output logic [HIST_W-1:0] hist_next
);
  sample_t           dly [HALF];
  acc_t              prod, x_new, x_q, y_new, y_q;
  logic [HIST_W-1:0] hist_q;

  always_comb begin
    prod      = dly[HALF-1] * sample;
    x_new     = (prod >>> 2) + (prod >>> 5);
    y_new     = x_q + x_new + (y_q >>> 2) + (y_q >>> 3) + (y_q >>> 4);
    hist_next = {hist_q[HIST_W-2:0], (y_new > $signed(PROD_W'(0)))};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dly[0] <= '0;
    else if (acc) dly[0] <= sample;
  end

  for (genvar i = 1; i < HALF; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (!rst_n) dly[i] <= '0;
      else if (acc) dly[i] <= dly[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      hist_q <= '0;
    end else if (acc) begin
      x_q    <= x_new;
      y_q    <= y_new;
      hist_q <= hist_next;
    end
  end

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])) // R3
    else $error("history did not shift");
  AST_FILTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(y_q) && $stable(hist_q)) // R2
    else $error("filter moved without a sample");
endmodule

// File: rtl/afsk_bitsync.sv
module afsk_bitsync #(
  parameter int HIST_W   = 5,
  parameter int PH_STEP  = 32,
  parameter int PH_RANGE = 256,
  parameter int PH_NUDGE = 4,
  parameter int VOTE_MIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [HIST_W-1:0] hist,
  output logic              bit_done,
  output logic              dec_bit
);
  localparam int PH_W  = $clog2(2 * PH_RANGE);
  localparam int VC_W  = $clog2(HIST_W + 1);

  logic [PH_W-1:0] phase_q, ph_adj, ph_sum, phase_next;
  logic [VC_W-1:0] ones;
  logic            vote, prev_q;

  always_comb begin
    ph_adj = phase_q;
    if (hist[1] != hist[0]) begin
      if (phase_q < PH_W'(PH_RANGE / 2)) ph_adj = phase_q + PH_W'(PH_NUDGE);
      else                               ph_adj = phase_q - PH_W'(PH_NUDGE);
    end
    ph_sum   = ph_adj + PH_W'(PH_STEP);
    bit_done = acc && (ph_sum >= PH_W'(PH_RANGE));
    phase_next = (ph_sum >= PH_W'(PH_RANGE)) ? ph_sum - PH_W'(PH_RANGE) : ph_sum;
    ones = '0;
    for (int i = 0; i < HIST_W; i++) ones = ones + VC_W'(hist[i]);
    vote    = (ones >= VC_W'(VOTE_MIN));
    dec_bit = (vote == prev_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      prev_q  <= 1'b0;
    end else if (acc) begin
      phase_q <= phase_next;
      if (bit_done) prev_q <= vote;
    end
  end

  // checker: spacing between produced bits
  logic [3:0] gap_q;
  logic       seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (acc) begin
      if (bit_done) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (gap_q != 4'hF) gap_q <= gap_q + 1'b1;
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < PH_W'(PH_RANGE)) // R5
    else $error("phase out of range");
  AST_BIT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_done && seen_q) |-> gap_q >= 4'd6) // R4
    else $error("bits too close together");
  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(phase_q)) // R4
    else $error("phase moved without a sample");
endmodule

// File: rtl/afsk_demod.sv
module afsk_demod
  import afsk_pkg::*;
#(
  parameter int DC_REMOVE = 1,
  parameter int RAW_W     = 12,
  parameter int HALF      = 4,
  parameter int AVG_LEN   = 192,
  parameter int OFF_LO    = 1300,
  parameter int OFF_HI    = 3300,
  parameter int OFF_DEF   = 2303,
  parameter int PH_STEP   = 32,
  parameter int PH_RANGE  = 256,
  parameter int PH_NUDGE  = 4,
  parameter int VOTE_N    = 5,
  parameter int VOTE_MIN  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [RAW_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_bit
);
  logic              acc, bit_done, dec_bit;
  sample_t           sample;
  logic [VOTE_N-1:0] hist_next;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  if (DC_REMOVE != 0) begin : g_dc
    afsk_dc_remove #(
      .RAW_W(RAW_W), .AVG_LEN(AVG_LEN), .OFF_LO(OFF_LO),
      .OFF_HI(OFF_HI), .OFF_DEF(OFF_DEF)
    ) u_dc (
      .clk(clk), .rst_n(rst_n), .acc(acc), .raw(in_data), .sample(sample)
    );
  end else begin : g_direct
    assign sample = in_data[SAMPLE_W-1:0];
  end

  afsk_discrim #(.HALF(HALF), .HIST_W(VOTE_N)) u_disc (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sample(sample), .hist_next(hist_next)
  );

  afsk_bitsync #(
    .HIST_W(VOTE_N), .PH_STEP(PH_STEP), .PH_RANGE(PH_RANGE),
    .PH_NUDGE(PH_NUDGE), .VOTE_MIN(VOTE_MIN)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .acc(acc), .hist(hist_next),
    .bit_done(bit_done), .dec_bit(dec_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (bit_done) begin
      out_valid <= 1'b1;
      out_bit   <= dec_bit;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit))) // R8
    else $error("pending bit lost");
  AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready) // R8
    else $error("sample taken while stalled");
endmodule

// File: tb/afsk_demod_bench.sv
module afsk_demod_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_data = '0;
  logic        out_ready = 1'b1;
  logic        rdy0, ov0, ob0, rdy1, ov1, ob1;

  always #10 clk = ~clk;

  afsk_demod #(.DC_REMOVE(1)) u_afsk_demod (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy0),
    .in_data(in_data), .out_valid(ov0), .out_ready(out_ready), .out_bit(ob0));

  afsk_demod #(.DC_REMOVE(0)) u_afsk_demod_raw (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1),
    .in_data(in_data), .out_valid(ov1), .out_ready(1'b1), .out_bit(ob1));

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // behavioural reference state, index 0 = front end on, 1 = off
  int dq0[$], dq1[$];
  int xq[2], yq[2], hist[2], phase[2], prevv[2];
  int dsum, dcnt, doff;
  bit ev[2], eb[2];

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic model_reset();
    dq0.delete(); dq1.delete();
    for (int i = 0; i < 4; i++) begin dq0.push_back(0); dq1.push_back(0); end
    for (int k = 0; k < 2; k++) begin
      xq[k] = 0; yq[k] = 0; hist[k] = 0; phase[k] = 0; prevv[k] = 0;
      ev[k] = 0; eb[k] = 0;
    end
    dsum = 0; dcnt = 0; doff = 2303;
  endtask

  function automatic int s8(int v);
    int t = v & 255;
    return (t > 127) ? t - 256 : t;
  endfunction

  function automatic int s16(int v);
    int t = v & 65535;
    return (t > 32767) ? t - 65536 : t;
  endfunction

  // one accepted sample; returns 1 when a bit is produced
  task automatic model_take(int k, int raw, output bit emit, output bit ob);
    int s, d, p, x, y, ones, vote;
    if (k == 0) begin // R7
      dsum += raw; dcnt++;
      if (dcnt >= 192) begin
        doff = dsum / 192; dsum = 0; dcnt = 0;
        if (doff > 3300 || doff < 1300) doff = 2303;
      end
      s = s8((raw - doff) >>> 4);
      d = dq0.pop_front(); dq0.push_back(s);
    end else begin    // R10
      s = s8(raw);
      d = dq1.pop_front(); dq1.push_back(s);
    end
    p = d * s;                                 // R1 R2
    x = (p >>> 2) + (p >>> 5);
    y = s16(xq[k] + x + (yq[k] >>> 2) + (yq[k] >>> 3) + (yq[k] >>> 4));
    xq[k] = x; yq[k] = y;
    hist[k] = ((hist[k] << 1) | (y > 0 ? 1 : 0)) & 31;   // R3
    if (((hist[k] ^ (hist[k] >> 1)) & 1) != 0)           // R4
      phase[k] = (phase[k] < 128) ? phase[k] + 4 : phase[k] - 4;
    phase[k] += 32;
    emit = 0; ob = 0;
    if (phase[k] >= 256) begin                           // R5
      phase[k] -= 256;
      ones = $countones(hist[k]);
      vote = (ones >= 3) ? 1 : 0;
      ob = (vote == prevv[k]);                           // R6
      prevv[k] = vote;
      emit = 1;
    end
  endtask

  // one cycle: check, drive, advance model; returns whether sample taken
  task automatic cycle(bit v, int raw, bit ordy, output bit took);
    bit e, b, r0;
    @(negedge clk);
    check(rdy0 == (!ev[0] || out_ready), "R8 in_ready", rdy0, !ev[0] || out_ready);
    check(ov0 == ev[0], "R5 R7 R8 out_valid", ov0, ev[0]);
    if (ev[0]) check(ob0 == eb[0], "R2 R3 R4 R6 R7 out_bit", ob0, eb[0]);
    check(ov1 == ev[1], "R1 R5 R10 out_valid", ov1, ev[1]);
    if (ev[1]) check(ob1 == eb[1], "R2 R3 R4 R6 R10 out_bit", ob1, eb[1]);
    in_valid  = v;
    in_data   = raw[11:0];
    out_ready = ordy;
    r0 = !ev[0] || ordy;
    took = v && r0;
    if (took) begin
      model_take(0, raw, e, b);
      if (e) begin ev[0] = 1; eb[0] = b; end else if (ordy) ev[0] = 0;
    end else if (ordy) ev[0] = 0;
    if (v) begin
      model_take(1, raw & 255, e, b);
      ev[1] = e; if (e) eb[1] = b;
    end else ev[1] = 0;
  endtask

  real ph;
  bit  curbit;

  task automatic run(int n, int dc, int amp, int vpct, int rpct, bit noise, bit junk_hi);
    bit took;
    int raw;
    for (int i = 0; i < n; i++) begin
      if (i % 8 == 0) curbit = $urandom_range(1, 0);
      ph += 6.283185307 * (curbit ? 1200.0 : 2200.0) / 9600.0;
      if (noise) raw = $urandom_range(4095, 0);
      else raw = dc + $rtoi(amp * $sin(ph));
      if (raw < 0) raw = 0;
      if (raw > 4095) raw = 4095;
      if (junk_hi) raw = (raw & 255) | ($urandom_range(15, 0) << 8);
      took = 0;
      while (!took && !done) begin
        if ($urandom_range(99, 0) < vpct)
          cycle(1'b1, raw, ($urandom_range(99, 0) < rpct), took);
        else
          cycle(1'b0, raw, ($urandom_range(99, 0) < rpct), took);
      end
    end
  endtask

  initial begin
    bit t;
    model_reset();
    ph = 0.0;
    repeat (4) @(negedge clk);
    // R9: reset state at the ports
    check(ov0 == 1'b0, "R9 out_valid in reset", ov0, 0);
    check(rdy0 == 1'b1, "R9 in_ready in reset", rdy0, 1);
    check(ov1 == 1'b0, "R9 raw out_valid in reset", ov1, 0);
    rst_n = 1'b1;
    // R1: first samples see a zero-filled delay line
    run(12, 2048, 1500, 100, 100, 0, 0);
    run(4000, 2048, 1500, 100, 100, 0, 0);
    run(4000, 2100, 1200, 80, 50, 0, 0);   // R8 stalls
    run(2500, 3700, 300, 100, 70, 0, 0);   // R7 average above window
    run(2500, 800, 300, 100, 70, 0, 0);    // R7 average below window
    run(2500, 0, 0, 90, 60, 1, 0);         // noise: many R4 nudges
    run(2500, 2048, 1000, 100, 100, 0, 1); // R10 upper bits toggled
    cycle(1'b0, 0, 1'b1, t);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule